// File: doc/BRIEF.md
# Sensor-Gated Integrity Check Controller

This controller decides when a memory integrity verifier has to run, so that the verifier does not spend energy on every memory access. A sensor reports a possible physical attack. The sensor is modelled here as an equality test between a block index and an attack seed, sampled on each memory access. In the idle monitoring state the verifier stays off. When an anomaly is seen, the controller turns the verifier on for a window counted in memory accesses. Each further anomaly inside the window refills the window. When the window runs out with no new anomaly, the verifier is turned off for one detach cycle and monitoring starts again.

Two running counters are brought out: the number of accepted anomaly events and the number of accesses made while the verifier was on. From these a test can work out what share of the traffic was checked and how much energy was saved. The index and seed width is a parameter limited to 16, 20 or 24 bits. The window length is a parameter limited to 2000, 8000 or 15000 accesses.

Top module: `anomaly_gated_verifier_ctrl`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `gate_state` reads 0 (monitor), `ver_en` is 0, and `win_left`, `anomaly_count` and `verified_accesses` are all 0.
- R2: An anomaly is a cycle with `acc_vld` high and `blk_idx` equal to `atk_seed` in every one of the IDX_W bits; a cycle without `acc_vld` is never an anomaly. An anomaly in monitor state puts the controller in verify state (`gate_state` = 1, `ver_en` = 1) after the next clock edge, with `win_left` equal to WINDOW.
- R3: In verify state, each access that is not an anomaly lowers `win_left` by exactly one. A cycle without `acc_vld` leaves `win_left` unchanged.
- R4: An anomaly in verify state reloads `win_left` to WINDOW. `win_left` never exceeds WINDOW.
- R5: A non-anomalous access made when `win_left` is 1 moves the controller to detach state (`gate_state` = 2, `ver_en` = 0, `win_left` = 0). An anomaly on that last access counts as an extension and not as an expiry.
- R6: Detach state lasts exactly one cycle and is followed by monitor state. Accesses and anomalies seen during detach have no effect on any output.
- R7: `anomaly_count` rises by one for each anomaly accepted in monitor or verify state, and for nothing else.
- R8: `verified_accesses` rises by one for each access made in verify state, whether or not it is an anomaly, and for nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_vld | input | 1 | Memory access strobe, one per access |
| blk_idx | input | IDX_W | Randomly chosen block index |
| atk_seed | input | IDX_W | Attack seed from the sensor model |
| ver_en | output | 1 | Enable for the integrity verifier |
| gate_state | output | 2 | 0 monitor, 1 verify, 2 detach |
| win_left | output | $clog2(WINDOW+1) | Accesses left in the open window |
| anomaly_count | output | STAT_W | Accepted anomaly events |
| verified_accesses | output | STAT_W | Accesses made with the verifier on |

## Verification
The main function is driven in several ways:
- A stream of accesses that never match shows that monitor state is left alone.
- Matches made without the strobe, and indices that differ from the seed only in the top bit, show that only a full-width strobed match wakes the verifier.
- An uninterrupted run of WINDOW quiet accesses shows the exact point of expiry. Idle cycles placed inside the window show that the count depends on accesses and not on time.
- A match on the last access of a window tells extension apart from expiry. A match during the detach cycle shows that detach ignores input.
- Random traffic with rare seeded matches and gaps in the strobe is compared with a bench model on every cycle. This mixes extensions, expiries and re-arming in unplanned orders.

// File: rtl/sgic_pkg.sv
package sgic_pkg;

    typedef enum logic [1:0] {
        ST_MONITOR = 2'd0,
        ST_VERIFY  = 2'd1,
        ST_DETACH  = 2'd2
    } gate_state_e;

    // bits needed to hold the values 0..n
    function automatic int cnt_bits(input int n);
        return $clog2(n + 1);
    endfunction

endpackage

// File: rtl/anomaly_match.sv
module anomaly_match #(
    parameter int IDX_W = 16
) (
    input  logic             acc_vld,
    input  logic [IDX_W-1:0] blk_idx,
    input  logic [IDX_W-1:0] atk_seed,
    output logic             hit
);
    // the sensor is only sampled on a real memory access
    always_comb hit = acc_vld && (blk_idx == atk_seed);
endmodule

// File: rtl/window_fsm.sv
module window_fsm
    import sgic_pkg::*;
#(
    parameter int WINDOW = 2000,
    localparam int WIN_W = cnt_bits(WINDOW)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_vld,
    input  logic             hit,
    output gate_state_e      state,
    output logic [WIN_W-1:0] remaining,
    output logic             accept_hit,
    output logic             ver_access
);
    localparam logic [WIN_W-1:0] WIN_FULL = WIN_W'(WINDOW);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(1);

    always_comb begin
        accept_hit = hit && (state != ST_DETACH);
        ver_access = acc_vld && (state == ST_VERIFY);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_MONITOR;
            remaining <= '0;
        end else begin
            unique case (state)
                ST_MONITOR: begin
                    if (hit) begin
                        state     <= ST_VERIFY;
                        remaining <= WIN_FULL;
                    end
                end
                ST_VERIFY: begin
                    if (hit) begin
                        remaining <= WIN_FULL;          // extension wins over expiry
                    end else if (acc_vld) begin
                        if (remaining == WIN_LAST) begin
                            state     <= ST_DETACH;
                            remaining <= '0;
                        end else begin
                            remaining <= remaining - WIN_LAST;
                        end
                    end
                end
                default: begin
                    state <= ST_MONITOR;               // detach lasts one cycle
                end
            endcase
        end
    end

    a_r2_wake: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MONITOR && hit) |=> (state == ST_VERIFY && remaining == WIN_FULL));
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VERIFY && !acc_vld) |=> $stable(remaining));
    a_r4_cap: assert property (@(posedge clk) disable iff (rst)
        remaining <= WIN_FULL);
    a_r5_live_window: assert property (@(posedge clk) disable iff (rst)
        (state == ST_VERIFY) |-> (remaining != '0));
    a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DETACH) |=> (state == ST_MONITOR));
endmodule

// File: rtl/event_stats.sv
module event_stats #(
    parameter int STAT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_hit,
    input  logic              ver_access,
    output logic [STAT_W-1:0] anomalies,
    output logic [STAT_W-1:0] checked
);
    always_ff @(posedge clk) begin
        if (rst) begin
            anomalies <= '0;
            checked   <= '0;
        end else begin
            if (accept_hit) anomalies <= anomalies + STAT_W'(1);
            if (ver_access) checked   <= checked + STAT_W'(1);
        end
    end
endmodule

// File: rtl/anomaly_gated_verifier_ctrl.sv
module anomaly_gated_verifier_ctrl
    import sgic_pkg::*;
#(
    parameter int IDX_W  = 16,
    parameter int WINDOW = 2000,
    parameter int STAT_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acc_vld,
    input  logic [IDX_W-1:0]              blk_idx,
    input  logic [IDX_W-1:0]              atk_seed,
    output logic                          ver_en,
    output logic [1:0]                    gate_state,
    output logic [$clog2(WINDOW+1)-1:0]   win_left,
    output logic [STAT_W-1:0]             anomaly_count,
    output logic [STAT_W-1:0]             verified_accesses
);
    localparam int WIN_W = cnt_bits(WINDOW);

    logic             hit;
    logic             accept_hit;
    logic             ver_access;
    gate_state_e      state;
    logic [WIN_W-1:0] remaining;

    initial begin
        a_param_idx_w: assert (IDX_W == 16 || IDX_W == 20 || IDX_W == 24)
            else $error("IDX_W must be 16, 20 or 24");
        a_param_window: assert (WINDOW == 2000 || WINDOW == 8000 || WINDOW == 15000)
            else $error("WINDOW must be 2000, 8000 or 15000");
    end

    anomaly_match #(.IDX_W(IDX_W)) u_match (
        .acc_vld  (acc_vld),
        .blk_idx  (blk_idx),
        .atk_seed (atk_seed),
        .hit      (hit)
    );

    window_fsm #(.WINDOW(WINDOW)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .acc_vld    (acc_vld),
        .hit        (hit),
        .state      (state),
        .remaining  (remaining),
        .accept_hit (accept_hit),
        .ver_access (ver_access)
    );

    event_stats #(.STAT_W(STAT_W)) u_stats (
        .clk        (clk),
        .rst        (rst),
        .accept_hit (accept_hit),
        .ver_access (ver_access),
        .anomalies  (anomaly_count),
        .checked    (verified_accesses)
    );

    always_comb begin
        ver_en     = (state == ST_VERIFY);
        gate_state = state;
        win_left   = remaining;
    end

    a_r7_count_on_wake: assert property (@(posedge clk) disable iff (rst)
        (state == ST_MONITOR && acc_vld && blk_idx == atk_seed)
        |=> (anomaly_count != $past(anomaly_count)));
    a_r6_detach_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DETACH) |=> ($stable(anomaly_count) && $stable(verified_accesses)));
    a_r8_count_checked: assert property (@(posedge clk) disable iff (rst)
        (ver_en && acc_vld) |=> (verified_accesses != $past(verified_accesses)));
endmodule

// File: tb/anomaly_gated_verifier_ctrl_bench.sv
module anomaly_gated_verifier_ctrl_bench;
    localparam int IDX_W  = 16;
    localparam int WINDOW = 2000;
    localparam int STAT_W = 32;
    localparam int WIN_W  = $clog2(WINDOW + 1);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              acc_vld = 1'b0;
    logic [IDX_W-1:0]  blk_idx = '0;
    logic [IDX_W-1:0]  atk_seed = '1;
    logic              ver_en;
    logic [1:0]        gate_state;
    logic [WIN_W-1:0]  win_left;
    logic [STAT_W-1:0] anomaly_count;
    logic [STAT_W-1:0] verified_accesses;

    int total = 0;
    int bad   = 0;

    // bench model of the expected behaviour
    int     m_state = 0;
    int     m_rem   = 0;
    longint m_anom  = 0;
    longint m_vacc  = 0;

    anomaly_gated_verifier_ctrl #(
        .IDX_W(IDX_W), .WINDOW(WINDOW), .STAT_W(STAT_W)
    ) u_anomaly_gated_verifier_ctrl (
        .clk               (clk),
        .rst               (rst),
        .acc_vld           (acc_vld),
        .blk_idx           (blk_idx),
        .atk_seed          (atk_seed),
        .ver_en            (ver_en),
        .gate_state        (gate_state),
        .win_left          (win_left),
        .anomaly_count     (anomaly_count),
        .verified_accesses (verified_accesses)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input string what, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic model_step(input bit v, input logic [IDX_W-1:0] i, input logic [IDX_W-1:0] s);
        bit h;
        h = v && (i == s);
        case (m_state)
            0: if (h) begin m_state = 1; m_rem = WINDOW; m_anom++; end
            1: begin
                if (v) m_vacc++;
                if (h) begin
                    m_rem = WINDOW; m_anom++;
                end else if (v) begin
                    if (m_rem == 1) begin m_state = 2; m_rem = 0; end
                    else m_rem--;
                end
            end
            default: m_state = 0;
        endcase
    endtask

    task automatic compare_all();
        check("R2 R5 R6", "gate_state", longint'(gate_state), m_state);
        check("R2 R6", "ver_en", longint'(ver_en), (m_state == 1) ? 1 : 0);
        check("R3 R4", "win_left", longint'(win_left), m_rem);
        check("R7", "anomaly_count", longint'(anomaly_count), m_anom);
        check("R8", "verified_accesses", longint'(verified_accesses), m_vacc);
    endtask

    task automatic step(input bit v, input logic [IDX_W-1:0] i, input logic [IDX_W-1:0] s);
        @(negedge clk);
        acc_vld  = v;
        blk_idx  = i;
        atk_seed = s;
        model_step(v, i, s);
        @(posedge clk);
        #1;
        compare_all();
    endtask

    task automatic quiet_access();
        logic [IDX_W-1:0] a;
        a = IDX_W'($urandom);
        step(1'b1, a, a ^ IDX_W'(1));
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog R1 actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1c0ffee5));
        repeat (3) @(posedge clk);
        #1;
        check("R1", "gate_state in reset", longint'(gate_state), 0);
        check("R1", "ver_en in reset", longint'(ver_en), 0);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check("R1", "win_left after reset", longint'(win_left), 0);
        check("R1", "anomaly_count after reset", longint'(anomaly_count), 0);
        check("R1", "verified_accesses after reset", longint'(verified_accesses), 0);
        check("R1", "gate_state after reset", longint'(gate_state), 0);

        // R2: quiet accesses, unstrobed matches, near-miss in the top bit
        for (int k = 0; k < 8; k++) quiet_access();
        step(1'b0, 16'h1234, 16'h1234);
        check("R2", "unstrobed match ignored", longint'(gate_state), 0);
        step(1'b1, 16'h8abc, 16'h0abc);
        check("R2", "top-bit mismatch ignored", longint'(gate_state), 0);

        // R2: wake
        step(1'b1, 16'h5a5a, 16'h5a5a);
        check("R2", "wake state", longint'(gate_state), 1);
        check("R2", "wake window", longint'(win_left), WINDOW);

        // R3: idle cycles inside the window
        for (int k = 0; k < 5; k++) step(1'b0, 16'h0001, 16'h0002);
        check("R3", "idle keeps window", longint'(win_left), WINDOW);
        for (int k = 0; k < WINDOW - 1; k++) quiet_access();
        check("R3", "window down to one", longint'(win_left), 1);

        // R5 and R4: match on the final access extends
        step(1'b1, 16'h7777, 16'h7777);
        check("R5", "last-access match stays verify", longint'(gate_state), 1);
        check("R4", "reload to full window", longint'(win_left), WINDOW);

        // R5: quiet expiry
        for (int k = 0; k < WINDOW; k++) quiet_access();
        check("R5", "expiry to detach", longint'(gate_state), 2);
        check("R5", "ver_en off at detach", longint'(ver_en), 0);

        // R6: match during detach is ignored
        step(1'b1, 16'h4242, 16'h4242);
        check("R6", "detach returns to monitor", longint'(gate_state), 0);
        check("R6", "detach match not counted", longint'(anomaly_count), 2);
        quiet_access();
        check("R6", "still monitoring", longint'(gate_state), 0);

        // random traffic with rare seeded matches
        for (int k = 0; k < 30000; k++) begin
            logic [IDX_W-1:0] a;
            logic [IDX_W-1:0] b;
            bit v;
            v = ($urandom % 4) != 0;
            a = IDX_W'($urandom);
            b = (($urandom % 900) == 0) ? a : IDX_W'($urandom);
            step(v, a, b);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule